// File: doc/BRIEF.md
# Inter-Processor Interrupt Target Selector

This block takes one inter-processor interrupt command and works out which of `N_UNITS` local interrupt units should receive it. The command arrives as a 32-bit low command word and a 32-bit high word, qualified by a one-cycle send strobe. The block also receives the index of the sending unit and, for each unit, its 8-bit physical ID, its 8-bit logical ID, a format bit that selects flat or cluster logical addressing, and an enable bit.

The block checks each unit against the destination in parallel. Units can be addressed by physical ID, by flat logical bitmap, or by cluster logical ID. A destination shorthand overrides the address fields. The result is registered and comes out as a target mask with a one-cycle valid pulse. In lowest-priority delivery, a round-robin pointer reduces the matching set to at most one enabled unit. The block only selects targets; it does not inject any interrupt.

Top module: `ipi_dest_match`

## Requirements
- R1: After reset, `tgt_mask_o` is 0 and `tgt_valid_o` is 0. The round-robin pointer starts at `N_UNITS-1`, so the first lowest-priority search examines unit 0 first.
- R2: A send sampled on a rising edge produces its result at that same edge. `tgt_valid_o` is high for exactly one cycle. `tgt_mask_o` holds its value until the next send, and `tgt_valid_o` stays low when no send occurs.
- R3: With shorthand `cmd_lo_i[19:18]`=00 and `cmd_lo_i[11]`=0 (physical), unit u matches when `cmd_hi_i[31:24]` is 0xFF or equals its ID.
- R4: With shorthand 00, `cmd_lo_i[11]`=1, and `unit_cluster_i[u]`=0 (flat), unit u matches when its logical ID AND the destination is nonzero.
- R5: With shorthand 00, `cmd_lo_i[11]`=1, and `unit_cluster_i[u]`=1 (cluster), unit u matches when the upper nibbles of its logical ID and the destination are equal and the AND of their lower nibbles is nonzero.
- R6: Shorthand 01 (self) matches only the unit at `src_idx_i`, whatever the destination fields hold.
- R7: Shorthand 10 (all including self) matches every unit.
- R8: Shorthand 11 (all excluding self) matches every unit except `src_idx_i`.
- R9: When the delivery mode `cmd_lo_i[10:8]` is not 001, the mask equals the full match set, and `unit_en_i` has no effect.
- R10: When the delivery mode is 001 (lowest priority), the search runs from pointer+1 upward and wraps at `N_UNITS`. The mask is one-hot on the first unit that both matches and is enabled, and the pointer moves to that unit.
- R11: In lowest-priority mode, if no matching unit is enabled, the mask is 0 (with valid high) and the pointer does not change.
- R12: A send with any other delivery mode leaves the round-robin pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| send_i | input | 1 | Command strobe |
| cmd_lo_i | input | 32 | Low command word: shorthand [19:18], destination mode [11], delivery mode [10:8] |
| cmd_hi_i | input | 32 | High word; destination in [31:24] |
| src_idx_i | input | IDX_W | Index of the sending unit |
| unit_id_i | input | N_UNITS*8 | Physical IDs, unit u at [8u+7:8u] |
| unit_lid_i | input | N_UNITS*8 | Logical IDs, unit u at [8u+7:8u] |
| unit_cluster_i | input | N_UNITS | Per-unit format: 1 = cluster, 0 = flat |
| unit_en_i | input | N_UNITS | Per-unit enable for lowest-priority selection |
| tgt_mask_o | output | N_UNITS | Selected targets |
| tgt_valid_o | output | 1 | One-cycle pulse marking a new mask |

## Verification
A wrong match term for one unit shows up as a single flipped bit in the mask of the very next result, for that addressing mode only. A corrupted round-robin pointer is hidden at first. It becomes visible only at the next lowest-priority send, which picks a unit other than the first enabled match after the previous pick. The bench therefore chains lowest-priority sends back to back, and places sends of other delivery modes between them, so that any drift in the pointer is caught at the following result.

// File: rtl/ipi_dest_pkg.sv
package ipi_dest_pkg;
  localparam int unsigned DEST_W = 8;

  typedef enum logic [1:0] {
    SH_NONE     = 2'b00,
    SH_SELF     = 2'b01,
    SH_ALL_INC  = 2'b10,
    SH_ALL_EXC  = 2'b11
  } shorthand_e;

  localparam logic [2:0] DM_LOWEST = 3'b001;

  localparam int unsigned SH_LSB   = 18;
  localparam int unsigned DMODE_B  = 11;
  localparam int unsigned DLV_LSB  = 8;
  localparam int unsigned DEST_LSB = 24;
endpackage

// File: rtl/ipi_unit_match.sv
module ipi_unit_match
  import ipi_dest_pkg::*;
(
  input  shorthand_e         sh_i,
  input  logic               logical_i,
  input  logic [DEST_W-1:0]  dest_i,
  input  logic               is_src_i,
  input  logic [DEST_W-1:0]  id_i,
  input  logic [DEST_W-1:0]  lid_i,
  input  logic               cluster_i,
  output logic               match_o
);
  localparam int unsigned NIB = DEST_W / 2;

  logic phys_hit, flat_hit, clus_hit, addr_hit;

  assign phys_hit = (dest_i == {DEST_W{1'b1}}) || (dest_i == id_i);
  assign flat_hit = |(lid_i & dest_i);
  assign clus_hit = (lid_i[DEST_W-1:NIB] == dest_i[DEST_W-1:NIB]) &&
                    (|(lid_i[NIB-1:0] & dest_i[NIB-1:0]));
  assign addr_hit = !logical_i ? phys_hit : (cluster_i ? clus_hit : flat_hit);

  always_comb begin
    unique case (sh_i)
      SH_NONE:    match_o = addr_hit;
      SH_SELF:    match_o = is_src_i;
      SH_ALL_INC: match_o = 1'b1;
      SH_ALL_EXC: match_o = !is_src_i;
      default:    match_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipi_rr_select.sv
module ipi_rr_select #(
  parameter int unsigned N_UNITS = 4,
  localparam int unsigned IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic [IDX_W-1:0]   ptr_i,
  input  logic [N_UNITS-1:0] cand_i,
  output logic [N_UNITS-1:0] pick_o,
  output logic [IDX_W-1:0]   next_ptr_o
);
  always_comb begin
    logic found;
    found      = 1'b0;
    pick_o     = '0;
    next_ptr_o = ptr_i;
    // examine ptr+1 .. ptr (wrapping), first candidate wins
    for (int k = 1; k <= int'(N_UNITS); k++) begin
      int idx;
      idx = int'(ptr_i) + k;
      if (idx >= int'(N_UNITS)) idx = idx - int'(N_UNITS);
      if (!found && cand_i[idx]) begin
        found       = 1'b1;
        pick_o[idx] = 1'b1;
        next_ptr_o  = IDX_W'(idx);
      end
    end
  end
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
  import ipi_dest_pkg::*;
#(
  parameter int unsigned N_UNITS = 4,
  localparam int unsigned IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       send_i,
  input  logic [31:0]                cmd_lo_i,
  input  logic [31:0]                cmd_hi_i,
  input  logic [IDX_W-1:0]           src_idx_i,
  input  logic [N_UNITS*DEST_W-1:0]  unit_id_i,
  input  logic [N_UNITS*DEST_W-1:0]  unit_lid_i,
  input  logic [N_UNITS-1:0]         unit_cluster_i,
  input  logic [N_UNITS-1:0]         unit_en_i,
  output logic [N_UNITS-1:0]         tgt_mask_o,
  output logic                       tgt_valid_o
);
  shorthand_e          sh;
  logic                logical;
  logic                lowest;
  logic [DEST_W-1:0]   dest;
  logic [N_UNITS-1:0]  match;
  logic [N_UNITS-1:0]  rr_pick;
  logic [IDX_W-1:0]    rr_ptr_q, rr_ptr_nxt;
  logic [N_UNITS-1:0]  mask_nxt;
  logic                unused_bits;

  assign sh      = shorthand_e'(cmd_lo_i[SH_LSB +: 2]);
  assign logical = cmd_lo_i[DMODE_B];
  assign lowest  = (cmd_lo_i[DLV_LSB +: 3] == DM_LOWEST);
  assign dest    = cmd_hi_i[DEST_LSB +: DEST_W];
  assign unused_bits = ^{cmd_lo_i[31:20], cmd_lo_i[17:12], cmd_lo_i[7:0],
                         cmd_hi_i[DEST_LSB-1:0]};

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    ipi_unit_match u_match (
      .sh_i      (sh),
      .logical_i (logical),
      .dest_i    (dest),
      .is_src_i  (src_idx_i == IDX_W'(u)),
      .id_i      (unit_id_i[u*DEST_W +: DEST_W]),
      .lid_i     (unit_lid_i[u*DEST_W +: DEST_W]),
      .cluster_i (unit_cluster_i[u]),
      .match_o   (match[u])
    );
  end

  ipi_rr_select #(.N_UNITS(N_UNITS)) u_rr (
    .ptr_i      (rr_ptr_q),
    .cand_i     (match & unit_en_i),
    .pick_o     (rr_pick),
    .next_ptr_o (rr_ptr_nxt)
  );

  assign mask_nxt = lowest ? rr_pick : match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_ptr_q    <= IDX_W'(N_UNITS - 1);
      tgt_mask_o  <= '0;
      tgt_valid_o <= 1'b0;
    end else begin
      tgt_valid_o <= send_i;
      if (send_i) begin
        tgt_mask_o <= mask_nxt;
        if (lowest) rr_ptr_q <= rr_ptr_nxt;
      end
    end
  end
endmodule

// File: rtl/ipi_dest_match_chk.sv
module ipi_dest_match_chk
  import ipi_dest_pkg::*;
#(
  parameter int unsigned N_UNITS = 4,
  localparam int unsigned IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       send_i,
  input  logic [31:0]                cmd_lo_i,
  input  logic [31:0]                cmd_hi_i,
  input  logic [IDX_W-1:0]           src_idx_i,
  input  logic [N_UNITS*DEST_W-1:0]  unit_id_i,
  input  logic [N_UNITS*DEST_W-1:0]  unit_lid_i,
  input  logic [N_UNITS-1:0]         unit_cluster_i,
  input  logic [N_UNITS-1:0]         unit_en_i,
  input  logic [N_UNITS-1:0]         tgt_mask_o,
  input  logic                       tgt_valid_o
);
  // R2
  valid_follows_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |-> $past(send_i));
  // R2
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(send_i) |-> $stable(tgt_mask_o));
  // R10
  lowest_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_valid_o && $past(cmd_lo_i[10:8]) == DM_LOWEST) |-> $onehot0(tgt_mask_o));
  // R10
  lowest_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_valid_o && $past(cmd_lo_i[10:8]) == DM_LOWEST) |-> ((tgt_mask_o & ~$past(unit_en_i)) == '0));
  // R7
  all_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(send_i && cmd_lo_i[19:18] == 2'b10 && cmd_lo_i[10:8] != DM_LOWEST)
      |-> (tgt_mask_o == {N_UNITS{1'b1}}));
  // R8
  all_exc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(send_i && cmd_lo_i[19:18] == 2'b11 && cmd_lo_i[10:8] != DM_LOWEST)
      |-> ($countones(tgt_mask_o) == N_UNITS - 1 && !tgt_mask_o[$past(src_idx_i)]));
  // R6
  self_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(send_i && cmd_lo_i[19:18] == 2'b01) |-> ($countones(tgt_mask_o) <= 1));
endmodule

bind ipi_dest_match ipi_dest_match_chk #(.N_UNITS(N_UNITS)) u_chk (.*);

// File: tb/tb_ipi_dest_match.sv
module tb_ipi_dest_match;
  localparam int N = 4;
  localparam int IW = 2;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic          send_i = 0;
  logic [31:0]   cmd_lo_i = '0;
  logic [31:0]   cmd_hi_i = '0;
  logic [IW-1:0] src_idx_i = '0;
  logic [N*8-1:0] unit_id_i, unit_lid_i;
  logic [N-1:0]  unit_cluster_i = '0;
  logic [N-1:0]  unit_en_i = '1;
  logic [N-1:0]  tgt_mask_o;
  logic          tgt_valid_o;

  int total = 0, bad = 0;
  int ptr_m = N - 1;

  always #5 clk_i = ~clk_i;

  ipi_dest_match #(.N_UNITS(N)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model(input logic [31:0] lo, input logic [31:0] hi,
                                         input int src, input logic [N-1:0] en);
    logic [N-1:0] m;
    logic [7:0] d;
    d = hi[31:24];
    for (int u = 0; u < N; u++) begin
      logic [7:0] id, lid;
      id = unit_id_i[u*8 +: 8];
      lid = unit_lid_i[u*8 +: 8];
      case (lo[19:18])
        2'd0: if (!lo[11]) m[u] = (d == 8'hFF) || (d == id);
              else if (unit_cluster_i[u]) m[u] = (lid / 16 == d / 16) && ((lid % 16) & (d % 16)) != 0;
              else m[u] = (lid & d) != 0;
        2'd1: m[u] = (u == src);
        2'd2: m[u] = 1'b1;
        default: m[u] = (u != src);
      endcase
    end
    if (lo[10:8] == 3'b001) begin
      logic [N-1:0] p;
      p = '0;
      for (int k = 1; k <= N; k++) begin
        int i;
        i = (ptr_m + k) % N;
        if (p == 0 && m[i] && en[i]) begin
          p[i] = 1'b1;
          ptr_m = i;
        end
      end
      m = p;
    end
    return m;
  endfunction

  task automatic send(input string req, input logic [31:0] lo, input logic [31:0] hi,
                      input int src, input logic [N-1:0] en);
    logic [N-1:0] e;
    @(negedge clk_i);
    cmd_lo_i = lo; cmd_hi_i = hi; src_idx_i = IW'(src); unit_en_i = en;
    send_i = 1;
    e = model(lo, hi, src, en);
    @(negedge clk_i);
    send_i = 0;
    chk({req, " valid"}, 32'(tgt_valid_o), 32'd1);
    chk(req, 32'(tgt_mask_o), 32'(e));
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    unit_id_i  = {8'h40, 8'h25, 8'h11, 8'h03};
    unit_lid_i = {8'h24, 8'h21, 8'h12, 8'h11};
    repeat (3) @(negedge clk_i);
    // R1
    chk("R1 mask", 32'(tgt_mask_o), 0);
    chk("R1 valid", 32'(tgt_valid_o), 0);
    rst_ni = 1;
    // R1: first lowest search starts at unit 0
    send("R1 R10", 32'h0000_0100, 32'hFF00_0000, 0, 4'hF);
    @(negedge clk_i);
    // R2
    chk("R2 pulse", 32'(tgt_valid_o), 0);
    chk("R2 hold", 32'(tgt_mask_o), 32'h1);
    // R3 physical sweep
    for (int d = 0; d < 256; d++) send("R3", 32'h0, 32'(d) << 24, 1, 4'hF);
    // R4 flat sweep
    unit_cluster_i = 4'h0;
    for (int d = 0; d < 256; d++) send("R4", 32'h800, 32'(d) << 24, 2, 4'h0);
    // R5 cluster sweep, mixed formats too
    unit_cluster_i = 4'hF;
    for (int d = 0; d < 256; d++) send("R5", 32'h800, 32'(d) << 24, 3, 4'h0);
    unit_cluster_i = 4'h5;
    for (int d = 0; d < 256; d++) send("R4 R5", 32'h800, 32'(d) << 24, 0, 4'h0);
    // R6 R7 R8 shorthands override fields
    for (int s = 0; s < N; s++) begin
      send("R6", 32'h0004_0000, 32'h0300_0000, s, 4'h0);
      send("R7", 32'h0008_0800, 32'h0000_0000, s, 4'h0);
      send("R8", 32'h000C_0000, 32'hFF00_0000, s, 4'h0);
    end
    // R9 enables ignored in other delivery modes
    for (int e = 0; e < 16; e++) send("R9", 32'h0000_0000, 32'hFF00_0000, 0, 4'(e));
    // R10 R11 R12 lowest priority sweep with interleaved fixed sends
    for (int e = 0; e < 16; e++)
      for (int d = 0; d < 16; d++) begin
        unit_cluster_i = 4'h0;
        send("R10 R11", 32'h0000_0900, {4'h0, 4'(d), 24'h0}, 0, 4'(e));
        send("R12", 32'h0000_0000, 32'h2500_0000, 0, 4'(e));
        send("R10 R12", 32'h0008_0100, 32'h0, e % N, 4'(e));
      end
    // R11 none enabled then check pointer unchanged
    send("R11", 32'h0008_0100, 32'h0, 0, 4'h0);
    send("R11", 32'h0008_0100, 32'h0, 0, 4'hF);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule